// File: doc/BRIEF.md
# Time-Multiplexed Quadrature Phase Sequencer

This block is the sequencing core of a digital local oscillator. A single phase accumulator is shared across four sub-cycles of one super-cycle. The sub-cycles give, in turn, a cosine phase, a housekeeping slot, a sine phase and a source phase. Each super-cycle produces one sample set, and a downstream filter requests each set with a one-clock `sync_i` strobe.

Results pass through three stages. The current super-cycle generates phases. The set from the previous super-cycle sits in a rounding stage. The set before that is shifted out serially. A trigger input freezes the current cosine phase for a host to read. A self-test register keeps the most recent serial word so that the host can read it back.

Top module: `lo_phase_seq`

## Requirements
- R1: `slot_o` takes the Gray sequence 00 (cosine), 01 (housekeeping), 11 (sine), 10 (source), one clock per sub-cycle, with `run_o` high throughout. When idle, `run_o` is low and `slot_o` is 00.
- R2: A super-cycle starts on the clock after a sync request is pending and the serial shifter is idle. A `sync_i` pulse that arrives while the block is busy is remembered and served later.
- R3: The cosine phase is the accumulator plus 2^22 (a quarter turn, modulo 2^24). The sine phase is the accumulator. The source phase is the accumulator plus `src_ofs_i`, sampled in slot 10.
- R4: The accumulator adds the frequency word once per super-cycle, at the end of slot 10. `freq_i` is sampled only in slot 01, so changes at other times take effect from the next housekeeping slot.
- R5: The words shifted out after super-cycle n come from super-cycle n-1. The first transfer after reset carries zeros.
- R6: A transfer is 48 bits: the cosine word, then the sine word, then the source word, each MSB first. `ser_en_o` is high for each bit, and `frame_o` is high on the first bit of each word.
- R7: Each 16-bit word equals phase bits [23:8] plus phase bit 7, wrapping modulo 2^16.
- R8: A clock edge with `trig_i` high loads `cap_phase_o` with the current cosine phase (accumulator + 2^22). Otherwise `cap_phase_o` holds.
- R9: `st_word_o` holds the last 16 bits shifted out, and it changes only while `ser_en_o` is high.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freq_i | input | 24 | Phase increment per super-cycle |
| src_ofs_i | input | 24 | Source phase offset |
| sync_i | input | 1 | Request for the next sample set |
| trig_i | input | 1 | Cosine phase capture strobe |
| slot_o | output | 2 | Current sub-cycle code |
| run_o | output | 1 | Super-cycle in progress |
| ser_d_o | output | 1 | Serial data bit |
| ser_en_o | output | 1 | Serial bit valid (one per bit) |
| frame_o | output | 1 | First bit of a word |
| cap_phase_o | output | 24 | Captured cosine phase |
| st_word_o | output | 16 | Self-test readback of the last serial word |

## Verification
If the accumulator or the frequency register is wrong, the error shows in `cap_phase_o` after the next trigger. It also shows in the serial stream two super-cycles later, because of the pipeline delay. If the slot machine is wrong, `slot_o` and `run_o` differ within one clock, and the shifter may start in the wrong place. If the shifter count or load is off, `frame_o` or a data bit is misplaced within the same 48-bit transfer, and `st_word_o` is stale at its end. The bench therefore compares every output on every clock against a model driven by queues.

// File: rtl/lo_seq_pkg.sv
package lo_seq_pkg;
  typedef enum logic [1:0] {
    SL_COS = 2'b00,
    SL_HK  = 2'b01,
    SL_SIN = 2'b11,
    SL_SRC = 2'b10
  } slot_e;

  function automatic slot_e next_slot(slot_e s);
    case (s)
      SL_COS:  return SL_HK;
      SL_HK:   return SL_SIN;
      SL_SIN:  return SL_SRC;
      default: return SL_COS;
    endcase
  endfunction
endpackage

// File: rtl/lo_slot_fsm.sv
module lo_slot_fsm
  import lo_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_i,
  input  logic  shift_busy_i,
  output slot_e slot_o,
  output logic  run_o,
  output logic  last_o
);
  logic req_q;
  logic start;

  assign start  = !run_o && req_q && !shift_busy_i;
  assign last_o = run_o && (slot_o == SL_SRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o <= SL_COS;
      run_o  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (start) begin
        run_o <= 1'b1;
        req_q <= sync_i;
      end else begin
        req_q <= req_q | sync_i;
      end
      if (run_o) begin
        slot_o <= next_slot(slot_o);
        if (slot_o == SL_SRC) run_o <= 1'b0;
      end
    end
  end

  a_r1_idle_at_cos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> slot_o == SL_COS);
  a_r1_slot_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> slot_o != $past(slot_o));
  a_r1_ends_on_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(slot_o) == SL_SRC);
  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> !shift_busy_i);
endmodule

// File: rtl/lo_phase_gen.sv
module lo_phase_gen
  import lo_seq_pkg::*;
#(
  parameter int PH_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  slot_e           slot_i,
  input  logic            run_i,
  input  logic [PH_W-1:0] freq_i,
  input  logic [PH_W-1:0] ofs_i,
  input  logic            trig_i,
  output logic [PH_W-1:0] cos_o,
  output logic [PH_W-1:0] sin_o,
  output logic [PH_W-1:0] src_o,
  output logic [PH_W-1:0] cap_o
);
  localparam logic [PH_W-1:0] QUARTER = {2'b01, {(PH_W-2){1'b0}}};

  logic [PH_W-1:0] acc_q, freq_q;

  assign src_o = acc_q + ofs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      freq_q <= '0;
      cos_o  <= '0;
      sin_o  <= '0;
      cap_o  <= '0;
    end else begin
      if (run_i) begin
        case (slot_i)
          SL_COS:  cos_o  <= acc_q + QUARTER;
          SL_HK:   freq_q <= freq_i;
          SL_SIN:  sin_o  <= acc_q;
          default: acc_q  <= acc_q + freq_q;
        endcase
      end
      if (trig_i) cap_o <= acc_q + QUARTER;
    end
  end

  a_r4_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && slot_i == SL_SRC) |=> $stable(acc_q));
  a_r4_freq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && slot_i == SL_HK) |=> $stable(freq_q));
  a_r3_quadrature: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && slot_i == SL_SRC) |-> (cos_o - sin_o) == QUARTER);
  a_r8_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> $stable(cap_o));
endmodule

// File: rtl/lo_pipe_shift.sv
module lo_pipe_shift #(
  parameter int PH_W  = 24,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PH_W-1:0]  cos_i,
  input  logic [PH_W-1:0]  sin_i,
  input  logic [PH_W-1:0]  src_i,
  output logic             ser_d_o,
  output logic             ser_en_o,
  output logic             frame_o,
  output logic [OUT_W-1:0] st_o
);
  localparam int NWORD   = 3;
  localparam int FRAME_W = NWORD * OUT_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int RND_B   = PH_W - OUT_W - 1;

  logic [NWORD-1:0][PH_W-1:0]  set_q;
  logic [NWORD-1:0][OUT_W-1:0] word;
  logic [FRAME_W-1:0]          sh_q;
  logic [CNT_W-1:0]            cnt_q;

  // index NWORD-1 leaves first
  for (genvar g = 0; g < NWORD; g++) begin : g_round
    assign word[g] = set_q[g][PH_W-1 -: OUT_W] + OUT_W'(set_q[g][RND_B]);
  end

  assign ser_en_o = (cnt_q != '0);
  assign ser_d_o  = sh_q[FRAME_W-1];
  assign frame_o  = ser_en_o && ((cnt_q % CNT_W'(OUT_W)) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
      st_o  <= '0;
    end else if (load_i) begin
      sh_q  <= word;
      cnt_q <= CNT_W'(FRAME_W);
      set_q <= {cos_i, sin_i, src_i};
    end else if (ser_en_o) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
      st_o  <= {st_o[OUT_W-2:0], sh_q[FRAME_W-1]};
    end
  end

  a_r6_frame_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> ser_en_o);
  a_r6_load_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !ser_en_o);
  a_r6_burst_opens_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_en_o) |-> frame_o);
  a_r9_st_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_o |=> $stable(st_o));
endmodule

// File: rtl/lo_phase_seq.sv
module lo_phase_seq
  import lo_seq_pkg::*;
#(
  parameter int PH_W  = 24,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  freq_i,
  input  logic [PH_W-1:0]  src_ofs_i,
  input  logic             sync_i,
  input  logic             trig_i,
  output logic [1:0]       slot_o,
  output logic             run_o,
  output logic             ser_d_o,
  output logic             ser_en_o,
  output logic             frame_o,
  output logic [PH_W-1:0]  cap_phase_o,
  output logic [OUT_W-1:0] st_word_o
);
  slot_e           slot;
  logic            last;
  logic [PH_W-1:0] cos_ph, sin_ph, src_ph;

  assign slot_o = slot;

  lo_slot_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (sync_i),
    .shift_busy_i (ser_en_o),
    .slot_o       (slot),
    .run_o        (run_o),
    .last_o       (last)
  );

  lo_phase_gen #(.PH_W(PH_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (slot),
    .run_i  (run_o),
    .freq_i (freq_i),
    .ofs_i  (src_ofs_i),
    .trig_i (trig_i),
    .cos_o  (cos_ph),
    .sin_o  (sin_ph),
    .src_o  (src_ph),
    .cap_o  (cap_phase_o)
  );

  lo_pipe_shift #(.PH_W(PH_W), .OUT_W(OUT_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (last),
    .cos_i    (cos_ph),
    .sin_i    (sin_ph),
    .src_i    (src_ph),
    .ser_d_o  (ser_d_o),
    .ser_en_o (ser_en_o),
    .frame_o  (frame_o),
    .st_o     (st_word_o)
  );
endmodule

// File: tb/tb_lo_phase_seq.sv
module tb_lo_phase_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] freq_i = '0, src_ofs_i = '0;
  logic        sync_i = 1'b0, trig_i = 1'b0;
  logic [1:0]  slot_o;
  logic        run_o, ser_d_o, ser_en_o, frame_o;
  logic [23:0] cap_phase_o;
  logic [15:0] st_word_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lo_phase_seq dut (.*);

  // behavioural reference
  logic [23:0] m_acc, m_fq, m_cos, m_sin, m_cap;
  logic [23:0] m_prev[3];
  logic [15:0] m_st;
  bit          m_act, m_req;
  int          m_idx;
  bit          m_bits[$];

  function automatic logic [15:0] rnd16(logic [23:0] p);
    return p[23:8] + {15'd0, p[7]};
  endfunction

  function automatic logic [1:0] gray(int i);
    case (i)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc = 0; m_fq = 0; m_cos = 0; m_sin = 0; m_cap = 0; m_st = 0;
      m_act = 0; m_req = 0; m_idx = 0; m_bits.delete();
      for (int i = 0; i < 3; i++) m_prev[i] = 0;
    end else begin
      bit busy_pre, act_pre, start;
      busy_pre = (m_bits.size() != 0);
      act_pre  = m_act;
      start    = !act_pre && m_req && !busy_pre;
      if (trig_i) m_cap = m_acc + 24'h400000;
      if (busy_pre) begin
        bit b;
        b = m_bits.pop_front();
        m_st = {m_st[14:0], b};
      end
      if (act_pre) begin
        case (m_idx)
          0: m_cos = m_acc + 24'h400000;
          1: m_fq = freq_i;
          2: m_sin = m_acc;
          default: begin
            logic [23:0] src;
            src = m_acc + src_ofs_i;
            for (int w = 0; w < 3; w++) begin
              logic [15:0] wd;
              wd = rnd16(m_prev[w]);
              for (int k = 15; k >= 0; k--) m_bits.push_back(wd[k]);
            end
            m_prev[0] = m_cos; m_prev[1] = m_sin; m_prev[2] = src;
            m_acc = m_acc + m_fq;
            m_act = 0;
          end
        endcase
        m_idx = (m_idx + 1) % 4;
      end
      if (start) begin
        m_act = 1; m_idx = 0; m_req = sync_i;
      end else m_req = m_req | sync_i;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R1 R2 slot/run", {29'd0, run_o, slot_o},
          {29'd0, m_act, m_act ? gray(m_idx) : 2'b00});
      chk("R6 ser_en", {31'd0, ser_en_o}, {31'd0, m_bits.size() != 0});
      chk("R6 R5 R7 R3 R4 ser_d", {31'd0, ser_d_o},
          {31'd0, m_bits.size() != 0 ? m_bits[0] : 1'b0});
      chk("R6 frame", {31'd0, frame_o},
          {31'd0, (m_bits.size() != 0) && (m_bits.size() % 16 == 0)});
      chk("R8 R4 cap", {8'd0, cap_phase_o}, {8'd0, m_cap});
      chk("R9 st_word", {16'd0, st_word_o}, {16'd0, m_st});
    end
  end

  task automatic pulse_sync();
    @(negedge clk_i); sync_i = 1'b1;
    @(negedge clk_i); sync_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk_i);
    // R10: reset values
    chk("R10 reset slot/run", {29'd0, run_o, slot_o}, 32'd0);
    chk("R10 reset serial", {29'd0, ser_d_o, ser_en_o, frame_o}, 32'd0);
    chk("R10 reset cap", {8'd0, cap_phase_o}, 32'd0);
    chk("R10 reset st", {16'd0, st_word_o}, 32'd0);
    rst_ni = 1'b1;
    freq_i = 24'h012345;
    src_ofs_i = 24'h200000;
    idle(4);
    // R5: first transfer carries zeros, then real sets
    for (int i = 0; i < 20; i++) begin
      pulse_sync();
      for (int c = 0; c < 60; c++) begin
        @(negedge clk_i);
        trig_i = ($urandom % 9 == 0);
        if ($urandom % 13 == 0) freq_i = $urandom;   // R4 sampled only in slot 01
        if ($urandom % 17 == 0) src_ofs_i = $urandom;
      end
      trig_i = 1'b0;
    end
    // R2: sync while busy is held and served later
    pulse_sync();
    idle(10);
    pulse_sync();
    pulse_sync();
    idle(150);
    // R2: continuous requests, back-to-back sets
    @(negedge clk_i); sync_i = 1'b1;
    freq_i = 24'hFFF000;
    idle(300);
    sync_i = 1'b0;
    idle(80);
    // R7: rounding carry wraps the source word to zero
    src_ofs_i = 24'hFFFF80 - m_acc;
    pulse_sync();
    idle(70);
    src_ofs_i = 24'h00007F - m_acc;
    pulse_sync();
    idle(70);
    pulse_sync();
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    idle(80);
    summary();
  end
endmodule